// File: doc/BRIEF.md
# Epoch Snapshot Migration Engine

This engine runs in the background beside a row-granular undo logger. Its job is to bring a persistent memory image forward one finished epoch at a time, so that the image always matches some consistent past state of main memory. An epoch's undo log lists exactly the rows that the epoch wrote. For each logged row, the value that row held when the epoch ended is found by following the tag of that row's undo entry. The tag leads either to the next newer undo entry of the same row or, when no newer entry exists, back to the live main row.

The engine stages every after-image of an epoch in an external non-volatile buffer before it changes the image. It then raises a persistent commit flag that records how many rows were staged. Only after that does it copy the staged rows into the image, clear the flag and remove the epoch from the head of the pending list. If power fails during the copy, the flag remains set. After reset, a resume request replays the copy from the buffer. While the engine reads a live main row, it asks the logger to hold off writes to that row, so that data from the current epoch cannot leak into a past snapshot.

A tag pointer whose most significant bit is 0 addresses the main area. A set bit addresses the log area. The engine looks at the pending list once per scan interval and issues at most one strobe per cycle.

Top module: `mig_engine`

## Requirements
- R1: While the pending list is empty and no resume is requested, the engine raises none of rd_req, buf_we, cmt_we, img_we or ep_pop.
- R2: For entry i of the head epoch, the engine reads the row at the tag pointer of that entry's log row (lst_log). It then stages the result with buf_idx = i, buf_row = lst_row and buf_data = the returned read data. Entries are staged in order 0 to len-1.
- R3: wr_block is high, with wr_block_row equal to the row being read, from the cycle rd_req addresses a main-area row until rd_valid returns. It is low in the cycle after rd_valid. It is never raised for a log-area read.
- R4: The commit flag is written to 1 (cmt_we with cmt_val = 1) only after all len entries are staged, and cmt_cnt then equals len. No buffer write occurs while the flag is set.
- R5: After the flag is set, the engine writes image rows for buffer indices 0 to cnt-1 in order, each carrying that buffer slot's row and data. It then writes the flag to 0.
- R6: ep_pop pulses for one cycle only in the cycle right after the flag is cleared. Epochs are migrated strictly from the head of the list, oldest first.
- R7: The image is written only between setting and clearing the commit flag, or during a replay. Once all epochs are done, every logged row holds its end-of-epoch value and every other row is untouched.
- R8: While the persistent flag (nv_cmt) is 1, no new epoch is staged. A resume pulse in idle replays the copy of nv_cnt rows from the buffer, then clears the flag and pops the epoch.
- R9: An epoch with zero entries yields a flag set with count 0, then a flag clear and a pop, with no read and no image write.
- R10: During reset all strobes and wr_block are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_pending | input | 1 | Pending epoch list is non-empty |
| ep_id | input | EP_W | Identifier of the oldest pending epoch |
| ep_len | input | IDX_W+1 | Number of logged rows of that epoch |
| ep_pop | output | 1 | Remove the head epoch from the list |
| lst_ep | output | EP_W | Epoch whose row list is being read |
| lst_idx | output | IDX_W | Entry index in that list |
| lst_row | input | ROW_W | Main row of the entry |
| lst_log | input | ROW_W | Log row holding the entry's undo image |
| tag_addr | output | ROW_W | Tag memory address |
| tag_ptr | input | ROW_W | Tag contents (version chain pointer) |
| rd_req | output | 1 | Row read request pulse |
| rd_addr | output | ROW_W | Row to read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data |
| wr_block | output | 1 | Hold off logger writes to a main row |
| wr_block_row | output | ROW_W | Row being protected |
| buf_we | output | 1 | Staging buffer write |
| buf_idx | output | IDX_W | Staging slot |
| buf_row | output | ROW_W | Target row stored in the slot |
| buf_data | output | DATA_W | After-image stored in the slot |
| buf_rd_idx | output | IDX_W | Staging slot being copied |
| buf_rd_row | input | ROW_W | Target row of that slot |
| buf_rd_data | input | DATA_W | After-image of that slot |
| cmt_we | output | 1 | Persistent commit flag write |
| cmt_val | output | 1 | Flag value written |
| cmt_cnt | output | IDX_W+1 | Staged row count written with the flag |
| nv_cmt | input | 1 | Persisted commit flag |
| nv_cnt | input | IDX_W+1 | Persisted staged row count |
| resume | input | 1 | Request replay of an interrupted copy |
| img_we | output | 1 | Persistent image row write |
| img_row | output | ROW_W | Image row address |
| img_data | output | DATA_W | Image row data |

## Verification
The hardest case to reach is a power loss that lands between two image writes of one epoch's copy, with the commit flag already persisted. The bench counts image writes as they happen and pulls reset in the middle of the copy. Its buffer and flag model keeps its contents through the reset. The bench then leaves the epoch pending for several scan intervals to show that nothing is staged again, and finally pulses resume and expects the complete copy a second time. A second hard case is a logger write that races a main-row read. The bench tries to write each main row as soon as the read request appears and lets the write land only when wr_block falls, so a missing block would corrupt the staged after-image.

// File: rtl/mig_pkg.sv
package mig_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_REQ,
        ST_WAIT,
        ST_STAGE,
        ST_MARK,
        ST_COPY,
        ST_UNMARK,
        ST_POP
    } mig_state_e;
endpackage

// File: rtl/mig_scan_tick.sv
module mig_scan_tick #(
    parameter int PERIOD = 8,
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(PERIOD - 1));
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mig_walk_ctr.sv
module mig_walk_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] idx,
    output logic             last
);
    logic [CNT_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr)      idx_d = '0;
        else if (inc) idx_d = idx_q + CNT_W'(1);
        idx  = idx_q;
        last = ((idx_q + CNT_W'(1)) == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end
endmodule

// File: rtl/mig_area_decode.sv
module mig_area_decode #(
    parameter int ROW_W = 8
) (
    input  logic [ROW_W-1:0] ptr,
    output logic             in_main
);
    always_comb in_main = ~ptr[ROW_W-1];
endmodule

// File: rtl/mig_engine.sv
module mig_engine
    import mig_pkg::*;
#(
    parameter int ROW_W       = 8,
    parameter int DATA_W      = 16,
    parameter int EP_W        = 4,
    parameter int IDX_W       = 4,
    parameter int SCAN_PERIOD = 8,
    localparam int CNT_W      = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ep_pending,
    input  logic [EP_W-1:0]   ep_id,
    input  logic [CNT_W-1:0]  ep_len,
    output logic              ep_pop,
    output logic [EP_W-1:0]   lst_ep,
    output logic [IDX_W-1:0]  lst_idx,
    input  logic [ROW_W-1:0]  lst_row,
    input  logic [ROW_W-1:0]  lst_log,
    output logic [ROW_W-1:0]  tag_addr,
    input  logic [ROW_W-1:0]  tag_ptr,
    output logic              rd_req,
    output logic [ROW_W-1:0]  rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_block,
    output logic [ROW_W-1:0]  wr_block_row,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [ROW_W-1:0]  buf_row,
    output logic [DATA_W-1:0] buf_data,
    output logic [IDX_W-1:0]  buf_rd_idx,
    input  logic [ROW_W-1:0]  buf_rd_row,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic              cmt_we,
    output logic              cmt_val,
    output logic [CNT_W-1:0]  cmt_cnt,
    input  logic              nv_cmt,
    input  logic [CNT_W-1:0]  nv_cnt,
    input  logic              resume,
    output logic              img_we,
    output logic [ROW_W-1:0]  img_row,
    output logic [DATA_W-1:0] img_data
);
    typedef struct packed {
        mig_state_e        st;
        logic [EP_W-1:0]   ep;
        logic [CNT_W-1:0]  len;
        logic [ROW_W-1:0]  row;
        logic [ROW_W-1:0]  ptr;
        logic [DATA_W-1:0] data;
    } mig_regs_t;

    mig_regs_t r_d, r_q;

    logic             scan_tick;
    logic             ctr_clr, ctr_inc, ctr_last;
    logic [CNT_W-1:0] ctr_idx;
    logic             ptr_main;

    mig_scan_tick #(.PERIOD(SCAN_PERIOD)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (scan_tick)
    );

    mig_walk_ctr #(.CNT_W(CNT_W)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .lim   (r_q.len),
        .idx   (ctr_idx),
        .last  (ctr_last)
    );

    mig_area_decode #(.ROW_W(ROW_W)) u_area (
        .ptr     (r_q.ptr),
        .in_main (ptr_main)
    );

    // next-state and datapath
    always_comb begin
        r_d     = r_q;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                ctr_clr = 1'b1;
                if (resume && nv_cmt) begin
                    r_d.len = nv_cnt;
                    r_d.st  = (nv_cnt == '0) ? ST_UNMARK : ST_COPY;
                end else if (scan_tick && ep_pending && !nv_cmt) begin
                    r_d.ep  = ep_id;
                    r_d.len = ep_len;
                    r_d.st  = (ep_len == '0) ? ST_MARK : ST_FETCH;
                end
            end
            ST_FETCH: begin
                r_d.row = lst_row;
                r_d.ptr = tag_ptr;
                r_d.st  = ST_REQ;
            end
            ST_REQ: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    r_d.data = rd_data;
                    r_d.st   = ST_STAGE;
                end
            end
            ST_STAGE: begin
                ctr_inc = 1'b1;
                r_d.st  = ctr_last ? ST_MARK : ST_FETCH;
            end
            ST_MARK: begin
                ctr_clr = 1'b1;
                r_d.st  = (r_q.len == '0) ? ST_UNMARK : ST_COPY;
            end
            ST_COPY: begin
                ctr_inc = 1'b1;
                if (ctr_last) r_d.st = ST_UNMARK;
            end
            ST_UNMARK: r_d.st = ST_POP;
            ST_POP:    r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    // outputs decoded from registered state
    always_comb begin
        lst_ep       = r_q.ep;
        lst_idx      = ctr_idx[IDX_W-1:0];
        tag_addr     = lst_log;
        rd_req       = (r_q.st == ST_REQ);
        rd_addr      = r_q.ptr;
        wr_block     = ((r_q.st == ST_REQ) || (r_q.st == ST_WAIT)) && ptr_main;
        wr_block_row = r_q.ptr;
        buf_we       = (r_q.st == ST_STAGE);
        buf_idx      = ctr_idx[IDX_W-1:0];
        buf_row      = r_q.row;
        buf_data     = r_q.data;
        buf_rd_idx   = ctr_idx[IDX_W-1:0];
        cmt_we       = (r_q.st == ST_MARK) || (r_q.st == ST_UNMARK);
        cmt_val      = (r_q.st == ST_MARK);
        cmt_cnt      = (r_q.st == ST_MARK) ? r_q.len : '0;
        img_we       = (r_q.st == ST_COPY);
        img_row      = buf_rd_row;
        img_data     = buf_rd_data;
        ep_pop       = (r_q.st == ST_POP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/mig_engine_chk.sv
module mig_engine_chk #(
    parameter int ROW_W = 8,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic [ROW_W-1:0] rd_addr,
    input logic             rd_valid,
    input logic             wr_block,
    input logic [ROW_W-1:0] wr_block_row,
    input logic             buf_we,
    input logic             cmt_we,
    input logic             cmt_val,
    input logic [CNT_W-1:0] cmt_cnt,
    input logic             nv_cmt,
    input logic             img_we,
    input logic             ep_pop
);
    logic             armed_q;
    logic [CNT_W-1:0] staged_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            staged_q <= '0;
        end else begin
            if (cmt_we) armed_q <= cmt_val;
            if (cmt_we)      staged_q <= '0;
            else if (buf_we) staged_q <= staged_q + CNT_W'(1);
        end
    end

    a_r3_block_main: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_addr[ROW_W-1] |-> wr_block && wr_block_row == rd_addr);
    a_r3_no_block_log: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_addr[ROW_W-1] |-> !wr_block);
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && wr_block |=> !wr_block);
    a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_we && cmt_val |-> cmt_cnt == staged_q);
    a_r4_no_stage_armed: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !armed_q && !nv_cmt);
    a_r7_img_window: assert property (@(posedge clk) disable iff (!rst_n)
        img_we |-> armed_q || nv_cmt);
    a_r6_pop_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ep_pop |-> $past(cmt_we && !cmt_val));
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, buf_we, cmt_we, img_we, ep_pop}));
endmodule

bind mig_engine mig_engine_chk #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .wr_block     (wr_block),
    .wr_block_row (wr_block_row),
    .buf_we       (buf_we),
    .cmt_we       (cmt_we),
    .cmt_val      (cmt_val),
    .cmt_cnt      (cmt_cnt),
    .nv_cmt       (nv_cmt),
    .img_we       (img_we),
    .ep_pop       (ep_pop)
);

// File: tb/mig_engine_tb.sv
`timescale 1ns/1ps
module mig_engine_tb;
    localparam int ROW_W = 8, DATA_W = 16, EP_W = 4, IDX_W = 4, SCAN = 8;
    localparam int CNT_W = IDX_W + 1;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic ep_pending, ep_pop, rd_req, rd_valid, wr_block, buf_we, cmt_we, cmt_val;
    logic nv_cmt, resume, img_we;
    logic [EP_W-1:0]   ep_id, lst_ep;
    logic [CNT_W-1:0]  ep_len, cmt_cnt, nv_cnt;
    logic [IDX_W-1:0]  lst_idx, buf_idx, buf_rd_idx;
    logic [ROW_W-1:0]  lst_row, lst_log, tag_addr, tag_ptr, rd_addr, wr_block_row;
    logic [ROW_W-1:0]  buf_row, buf_rd_row, img_row;
    logic [DATA_W-1:0] rd_data, buf_data, buf_rd_data, img_data;

    logic [DATA_W-1:0] mem     [256];
    logic [ROW_W-1:0]  tagm    [256];
    logic [ROW_W-1:0]  ent_row [16][16];
    logic [ROW_W-1:0]  ent_log [16][16];
    logic [CNT_W-1:0]  eplen   [16];
    logic [ROW_W-1:0]  nvb_row [16];
    logic [DATA_W-1:0] nvb_dat [16];
    logic [DATA_W-1:0] img     [128];
    logic [DATA_W-1:0] img_exp [128];
    int epq[$];

    assign lst_row     = ent_row[lst_ep][lst_idx];
    assign lst_log     = ent_log[lst_ep][lst_idx];
    assign tag_ptr     = tagm[tag_addr];
    assign buf_rd_row  = nvb_row[buf_rd_idx];
    assign buf_rd_data = nvb_dat[buf_rd_idx];

    mig_engine #(.ROW_W(ROW_W), .DATA_W(DATA_W), .EP_W(EP_W), .IDX_W(IDX_W),
                 .SCAN_PERIOD(SCAN)) u_dut (.*);

    typedef struct { int k; int a; int b; int c; string r; } ev_t;
    localparam int K_BUF = 0, K_SET = 1, K_IMG = 2, K_CLR = 3, K_POP = 4;
    ev_t evq[$];
    int total = 0, bad = 0, n_ev = 0, n_rd = 0, n_buf = 0, n_img = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void set_head();
        if (epq.size() > 0) begin
            ep_pending = 1'b1;
            ep_id      = EP_W'(epq[0]);
            ep_len     = eplen[epq[0]];
        end else begin
            ep_pending = 1'b0;
            ep_id      = '0;
            ep_len     = '0;
        end
    endfunction

    function automatic void push_ev(input int k, input int a, input int b,
                                    input int c, input string r);
        ev_t e;
        e.k = k; e.a = a; e.b = b; e.c = c; e.r = r;
        evq.push_back(e);
    endfunction

    // driver: builds an epoch's version chains and the expected event stream
    task automatic add_epoch(input int id, input int n, input int base);
        for (int i = 0; i < n; i++) begin
            int r, l, p;
            r = base + i;
            l = 128 + (id - 1) * 8 + i;
            mem[l] = DATA_W'(16'h5000 + l);
            if (i % 2 == 0) p = r;
            else begin
                p = 200 + (id - 1) * 8 + i;
                mem[p] = DATA_W'(16'hA000 + id * 16 + i);
            end
            tagm[l] = ROW_W'(p);
            ent_row[id][i] = ROW_W'(r);
            ent_log[id][i] = ROW_W'(l);
            img_exp[r] = mem[p];
            push_ev(K_BUF, i, r, int'(mem[p]), "R2");
        end
        push_ev(K_SET, n, 0, 0, n == 0 ? "R9" : "R4");
        for (int i = 0; i < n; i++)
            push_ev(K_IMG, base + i, int'(img_exp[base + i]), 0, "R5");
        push_ev(K_CLR, 0, 0, 0, "R5");
        push_ev(K_POP, id, 0, 0, "R6");
        eplen[id] = CNT_W'(n);
        epq.push_back(id);
        set_head();
    endtask

    // read port model with a few cycles of latency
    logic [1:0] rd_cnt;
    logic       rd_pend;
    logic [ROW_W-1:0] rd_a;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 0; rd_pend <= 0; rd_cnt <= 0; rd_data <= 0; rd_a <= 0;
        end else begin
            rd_valid <= 0;
            if (rd_req) begin
                rd_pend <= 1; rd_cnt <= 2; rd_a <= rd_addr;
            end else if (rd_pend) begin
                if (rd_cnt == 0) begin
                    rd_valid <= 1; rd_data <= mem[rd_a]; rd_pend <= 0;
                end else rd_cnt <= rd_cnt - 1;
            end
        end
    end

    task automatic take(input int k, input int a, input int b, input int c);
        ev_t e;
        n_ev++;
        if (evq.size() == 0) begin
            chk(0, "R1", "unexpected strobe kind", k, -1);
            return;
        end
        e = evq.pop_front();
        chk(e.k == k, e.r, "strobe kind", k, e.k);
        if (e.k == k) begin
            chk(e.a == a, e.r, "field a", a, e.a);
            chk(e.b == b, e.r, "field b", b, e.b);
            chk(e.c == c, e.r, "field c", c, e.c);
        end
    endtask

    // monitor: logger model, persistent models, scoreboard compare
    logic pw_pend = 0, blk_seen = 0;
    logic [ROW_W-1:0]  pw_row;
    logic [DATA_W-1:0] pw_dat;
    always @(negedge clk) begin
        if (rst_n) begin
            if (blk_seen) chk(!wr_block, "R3", "block after rd_valid", int'(wr_block), 0);
            blk_seen = rd_valid && wr_block;
            if (pw_pend && !(wr_block && wr_block_row == pw_row)) begin
                mem[pw_row] = pw_dat;
                pw_pend = 0;
            end
            if (rd_req) begin
                n_rd++;
                chk(wr_block == !rd_addr[ROW_W-1], "R3", "block level", int'(wr_block),
                    int'(!rd_addr[ROW_W-1]));
                if (!rd_addr[ROW_W-1]) begin
                    chk(wr_block_row == rd_addr, "R3", "block row", int'(wr_block_row),
                        int'(rd_addr));
                    pw_pend = 1; pw_row = rd_addr; pw_dat = mem[rd_addr] ^ 16'hFFFF;
                end
            end
            if (buf_we) begin
                n_buf++;
                take(K_BUF, int'(buf_idx), int'(buf_row), int'(buf_data));
                nvb_row[buf_idx] = buf_row; nvb_dat[buf_idx] = buf_data;
            end
            if (cmt_we) begin
                take(cmt_val ? K_SET : K_CLR, cmt_val ? int'(cmt_cnt) : 0, 0, 0);
                nv_cmt = cmt_val;
                if (cmt_val) nv_cnt = cmt_cnt;
            end
            if (img_we) begin
                n_img++;
                take(K_IMG, int'(img_row), int'(img_data), 0);
                if (!img_row[ROW_W-1]) img[img_row[ROW_W-2:0]] = img_data;
            end
            if (ep_pop) begin
                take(K_POP, epq.size() > 0 ? epq[0] : -1, 0, 0);
                if (epq.size() > 0) void'(epq.pop_front());
                set_head();
            end
        end
    end

    task automatic drain(input string req);
        int w = 0;
        while (evq.size() != 0 && w < 3000) begin
            @(negedge clk); w++;
        end
        chk(evq.size() == 0, req, "events left after drain", evq.size(), 0);
    endtask

    initial begin
        #750000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ev0, rd0, buf0, tgt, mism;
        resume = 0; nv_cmt = 0; nv_cnt = 0;
        for (int a = 0; a < 256; a++) begin mem[a] = DATA_W'(16'h1000 + a * 7); tagm[a] = '0; end
        for (int a = 0; a < 128; a++) begin img[a] = '0; img_exp[a] = '0; end
        for (int e = 0; e < 16; e++) begin
            eplen[e] = '0; nvb_row[e] = '0; nvb_dat[e] = '0;
            for (int i = 0; i < 16; i++) begin ent_row[e][i] = '0; ent_log[e][i] = '0; end
        end
        set_head();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({rd_req, buf_we, cmt_we, img_we, ep_pop, wr_block} == '0, "R10",
            "strobes in reset", int'({rd_req, buf_we, cmt_we, img_we, ep_pop, wr_block}), 0);
        rst_n = 1;
        // R1: empty list, nothing happens
        ev0 = n_ev; rd0 = n_rd;
        repeat (40) @(negedge clk);
        chk(n_ev == ev0 && n_rd == rd0, "R1", "activity while list empty",
            n_ev - ev0 + n_rd - rd0, 0);
        // R2..R6: single epoch, mixed main and log pointers
        add_epoch(1, 3, 10);
        drain("R5");
        // R6: two epochs queued, oldest first
        add_epoch(2, 5, 20);
        add_epoch(3, 2, 40);
        drain("R6");
        // R9: empty epoch
        rd0 = n_rd;
        add_epoch(4, 0, 0);
        drain("R9");
        chk(n_rd == rd0, "R9", "reads for empty epoch", n_rd - rd0, 0);
        // R8: crash during the copy, then resume
        tgt = n_img + 2;
        add_epoch(5, 4, 60);
        while (n_img < tgt) @(negedge clk);
        #1 rst_n = 0;
        evq.delete();
        for (int i = 0; i < 4; i++) push_ev(K_IMG, 60 + i, int'(img_exp[60 + i]), 0, "R8");
        push_ev(K_CLR, 0, 0, 0, "R8");
        push_ev(K_POP, 5, 0, 0, "R8");
        repeat (3) @(negedge clk);
        chk(nv_cmt == 1'b1, "R8", "flag survives crash", int'(nv_cmt), 1);
        rst_n = 1;
        buf0 = n_buf; rd0 = n_rd;
        repeat (4 * SCAN) @(negedge clk);
        chk(n_buf == buf0 && n_rd == rd0, "R8", "restaging while flag set",
            n_buf - buf0 + n_rd - rd0, 0);
        chk(evq.size() == 6, "R8", "events before resume", evq.size(), 6);
        resume = 1;
        @(negedge clk);
        resume = 0;
        drain("R8");
        chk(nv_cmt == 1'b0, "R5", "flag after copy", int'(nv_cmt), 0);
        chk(epq.size() == 0, "R6", "epochs left", epq.size(), 0);
        // R7: image holds end-of-epoch values, other rows untouched
        mism = 0;
        for (int a = 0; a < 128; a++) if (img[a] !== img_exp[a]) mism++;
        chk(mism == 0, "R7", "image rows mismatching", mism, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule